// File: doc/BRIEF.md
# Register-Insertion Ring Node

This block is one station on a unidirectional ring of point-to-point links. Every cycle it takes one 16-bit symbol from its input link and puts one on its output link. A framing flag qualifies each symbol. Traffic addressed elsewhere flows through an internal bypass queue. A packet addressed to this station is taken off the ring, checked and stored in a receive queue, and a short echo packet is sent back to the sender in its place. The echo either accepts the packet or reports that the station is busy.

The local host loads one outbound packet at a time into a transmit buffer. The node slips this packet onto the ring only when the bypass queue is empty. Symbols that arrive while the packet is going out wait in the bypass queue and follow it. The packet stays in the buffer until an accept echo with the same tag comes back. A busy echo makes the node send the same packet again, up to a retry limit. After that limit the node drops the packet and reports a failure.

The framing rules are as follows. The flag is high from the header symbol through the last symbol, and at least one idle symbol separates any two packets. The last symbol is a CRC-16 with polynomial 0x1021, start value 0xFFFF, and data fed in MSB first, computed over the header and the data. A receiver that runs the same CRC over every symbol of a packet, the CRC symbol included, gets zero when the packet is intact. Header bits: [15:12] destination, [11:8] source, [7:6] kind (00 request, 01 response, 10 echo), [5] busy (echo only, 1 = busy), [4] zero, [3:0] tag.

Top module: `ring_node`

## Requirements
- R1: After reset the output link is idle (flag low), `tx_ready` is 1 and `rx_valid` is 0.
- R2: A packet whose destination is not `NODE_ID` leaves on the output link with every symbol unchanged and in order. Consecutive packets stay separated by at least one idle symbol.
- R3: The node starts one of its own packets or echoes only while the bypass queue is empty. Passing symbols that arrive during that insertion come out intact, after it ends.
- R4: An own packet is sent as a header, then the loaded data words in load order, then the CRC. The header is {`tx_dst`, `NODE_ID`, 0, `tx_kind`, 2'b00, `tx_tag`}.
- R5: A request or response for this node that has a valid CRC, a length of 2 to MAX_WORDS+2 symbols and enough receive space is stored in the receive queue. The queue gets the header with `rx_first`=1, then the data words. The CRC symbol is not stored.
- R6: The echo for a consumed packet has two symbols. The header is {source of that packet, `NODE_ID`, 2'b10, busy, 0, its tag}, and the second symbol is its CRC. The echo is never forwarded into the receive queue.
- R7: A packet for this node with a failed CRC leaves nothing in the receive queue and gets no echo of any kind.
- R8: If fewer than MAX_WORDS+2 receive entries are free when the header arrives, the packet is not stored. A busy echo (bit 5 = 1) is sent instead.
- R9: An accept echo whose source and tag match the outstanding packet pulses `tx_done` and raises `tx_ready` again.
- R10: A matching busy echo causes the same packet to be sent again. Once RETRY_LIMIT resends have been made, the next busy echo pulses `tx_fail` and frees the buffer without sending again.
- R11: An echo addressed to this node is removed from the ring. If its tag or source does not match the outstanding packet, it has no effect.
- R12: The bypass queue never holds more than its capacity, which covers one maximum-length insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_flag | input | 1 | Input link framing flag |
| in_data | input | 16 | Input link symbol |
| out_flag | output | 1 | Output link framing flag |
| out_data | output | 16 | Output link symbol |
| tx_wr | input | 1 | Append `tx_wdata` to the transmit buffer (only while ready) |
| tx_wdata | input | 16 | Outbound data word |
| tx_go | input | 1 | Send the loaded packet |
| tx_dst | input | 4 | Destination of the outbound packet |
| tx_tag | input | 4 | Tag of the outbound packet |
| tx_kind | input | 1 | 0 request, 1 response |
| tx_ready | output | 1 | Transmit buffer free |
| tx_done | output | 1 | One-cycle pulse on accept echo |
| tx_fail | output | 1 | One-cycle pulse when the retry limit is exhausted |
| rx_valid | output | 1 | Receive queue holds a committed word |
| rx_first | output | 1 | Current word is a packet header |
| rx_data | output | 16 | Current received word |
| rx_rd | input | 1 | Pop the current received word |

## Verification
The bench fires a transmit request while a long passing packet is streaming in. A node that ignored the bypass occupancy would cut the passing packet in two, and its symbols would show up around the node's own packet. A second case starts a passing packet just after an insertion begins. A design with too small a bypass queue, or one that merged packets by dropping the separating idle, would lose or join symbols there. On the receive side it covers four cases: a corrupted CRC, which a careless design would still store or acknowledge; a full receive queue, where a wrong design stores the packet or leaves out the busy bit; echoes with a wrong tag, which must not clear the transmit state; and the exact count of resends before `tx_fail`, where an off-by-one in the retry counter shows up.

// File: rtl/ring_node.sv
module ring_node #(
  parameter int NODE_ID     = 3,
  parameter int MAX_WORDS   = 32,
  parameter int RX_DEPTH    = 64,
  parameter int RETRY_LIMIT = 3,
  parameter int ECHO_DEPTH  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_flag,
  input  logic [15:0] in_data,
  output logic        out_flag,
  output logic [15:0] out_data,
  input  logic        tx_wr,
  input  logic [15:0] tx_wdata,
  input  logic        tx_go,
  input  logic [3:0]  tx_dst,
  input  logic [3:0]  tx_tag,
  input  logic        tx_kind,
  output logic        tx_ready,
  output logic        tx_done,
  output logic        tx_fail,
  output logic        rx_valid,
  output logic        rx_first,
  output logic [15:0] rx_data,
  input  logic        rx_rd
);
  localparam int BYP_AW   = $clog2(MAX_WORDS + 4);
  localparam int BYP_DEPTH = 1 << BYP_AW;
  localparam int RX_AW    = $clog2(RX_DEPTH);
  localparam int EQ_AW    = $clog2(ECHO_DEPTH);
  localparam int TXI_W    = $clog2(MAX_WORDS);
  localparam int TXC_W    = $clog2(MAX_WORDS + 1);
  localparam int IDX_W    = $clog2(MAX_WORDS + 3);
  localparam int LEN_W    = $clog2(MAX_WORDS + 4);
  localparam int RT_W     = $clog2(RETRY_LIMIT + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_WORDS + 2);
  localparam logic [RX_AW:0]   RX_LIM  = (RX_AW+1)'(RX_DEPTH - MAX_WORDS - 2);
  localparam logic [EQ_AW:0]   EQ_FULL = (EQ_AW+1)'(ECHO_DEPTH);
  localparam logic [3:0]       ID      = 4'(NODE_ID);
  localparam logic [1:0]       K_ECHO  = 2'b10;

  typedef enum logic [1:0] {T_IDLE, T_SEND, T_WAIT} tx_st_t;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 15; i >= 0; i--)
      r = (r[15] ^ d[i]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

  // ---------------- receive side ----------------
  logic             prev_flag, cur_mine, cur_store, cur_bsy;
  logic [3:0]       cur_src, cur_tag;
  logic [1:0]       cur_type;
  logic [LEN_W-1:0] cur_len;
  logic [15:0]      rx_crc;
  logic [16:0]      rx_mem [RX_DEPTH];
  logic [RX_AW:0]   wr_ptr, cm_ptr, rd_ptr;
  logic [15:0]      eq_mem [ECHO_DEPTH];
  logic [EQ_AW:0]   eq_wp, eq_rp;

  wire sop      = in_flag & ~prev_flag;
  wire eop      = ~in_flag & prev_flag;
  wire hdr_mine = in_data[15:12] == ID;
  wire mine_now = sop ? hdr_mine : cur_mine;
  wire [RX_AW:0] rx_used = wr_ptr - rd_ptr;
  wire store_now = sop ? (hdr_mine && in_data[7:6] != K_ECHO && rx_used <= RX_LIM) : cur_store;
  wire rx_wr    = in_flag & store_now & (sop | (cur_len < LEN_MAX));
  wire eq_full  = (eq_wp - eq_rp) == EQ_FULL;
  wire rx_good  = (rx_crc == 16'h0) && (cur_len >= LEN_W'(2)) && (cur_len <= LEN_MAX);
  wire end_data = eop & cur_mine & (cur_type != K_ECHO);
  wire eq_push  = end_data & rx_good & ~eq_full;
  wire echo_in  = eop & cur_mine & (cur_type == K_ECHO) & rx_good & (cur_len == LEN_W'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_flag <= 1'b0; cur_mine <= 1'b0; cur_store <= 1'b0; cur_bsy <= 1'b0;
      cur_src <= '0; cur_tag <= '0; cur_type <= '0; cur_len <= '0; rx_crc <= '0;
      wr_ptr <= '0; cm_ptr <= '0; eq_wp <= '0;
    end else begin
      prev_flag <= in_flag;
      if (sop) begin
        cur_mine  <= hdr_mine;
        cur_store <= store_now;
        cur_src   <= in_data[11:8];
        cur_type  <= in_data[7:6];
        cur_bsy   <= in_data[5];
        cur_tag   <= in_data[3:0];
        cur_len   <= LEN_W'(1);
        rx_crc    <= crc_step(16'hFFFF, in_data);
      end else if (in_flag) begin
        if (cur_len <= LEN_MAX) cur_len <= cur_len + LEN_W'(1);
        rx_crc <= crc_step(rx_crc, in_data);
      end
      if (rx_wr) begin
        rx_mem[wr_ptr[RX_AW-1:0]] <= {sop, in_data};
        wr_ptr <= wr_ptr + 1'b1;
      end else if (end_data && cur_store) begin
        if (rx_good && !eq_full) begin
          wr_ptr <= wr_ptr - 1'b1;
          cm_ptr <= wr_ptr - 1'b1;
        end else begin
          wr_ptr <= cm_ptr;
        end
      end
      if (eq_push) begin
        eq_mem[eq_wp[EQ_AW-1:0]] <= {cur_src, ID, K_ECHO, ~cur_store, 1'b0, cur_tag};
        eq_wp <= eq_wp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_ptr <= '0;
    else if (rx_rd && rx_valid) rd_ptr <= rd_ptr + 1'b1;
  end

  assign rx_valid = rd_ptr != cm_ptr;
  assign {rx_first, rx_data} = rx_mem[rd_ptr[RX_AW-1:0]];

  // ---------------- bypass queue ----------------
  logic [16:0]       byp_mem [BYP_DEPTH];
  logic [BYP_AW-1:0] byp_wp, byp_rp;
  logic [BYP_AW:0]   byp_cnt;
  logic              ins_on;

  wire byp_push = (in_flag & ~mine_now) | (eop & ~cur_mine);
  wire byp_pop  = ~ins_on & (byp_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_wp <= '0; byp_rp <= '0; byp_cnt <= '0;
    end else begin
      if (byp_push) begin
        byp_mem[byp_wp] <= {in_flag, in_flag ? in_data : 16'h0};
        byp_wp <= byp_wp + 1'b1;
      end
      if (byp_pop) byp_rp <= byp_rp + 1'b1;
      byp_cnt <= byp_cnt + (BYP_AW+1)'(byp_push) - (BYP_AW+1)'(byp_pop);
    end
  end

  // ---------------- transmit and output ----------------
  tx_st_t           tx_st;
  logic [15:0]      tx_buf [MAX_WORDS];
  logic [TXC_W-1:0] tx_n;
  logic [3:0]       t_dst, t_tag;
  logic             t_kind, ins_echo;
  logic [RT_W-1:0]  rcnt;
  logic [IDX_W-1:0] ins_idx;
  logic [15:0]      ocrc;

  wire [15:0]      tx_hdr  = {t_dst, ID, 1'b0, t_kind, 2'b00, t_tag};
  wire [IDX_W-1:0] ins_len = ins_echo ? '0 : IDX_W'(tx_n);
  wire [15:0]      tx_word = tx_buf[TXI_W'(ins_idx - 1'b1)];
  wire             eq_any  = eq_wp != eq_rp;
  wire             can_ins = ~ins_on & (byp_cnt == '0);
  wire             echo_hit = echo_in & (tx_st == T_WAIT) & (cur_tag == t_tag) & (cur_src == t_dst);

  assign tx_ready = tx_st == T_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st <= T_IDLE; tx_n <= '0; t_dst <= '0; t_tag <= '0; t_kind <= 1'b0;
      rcnt <= '0; ins_on <= 1'b0; ins_echo <= 1'b0; ins_idx <= '0; ocrc <= '0;
      eq_rp <= '0; out_flag <= 1'b0; out_data <= '0; tx_done <= 1'b0; tx_fail <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      tx_fail <= 1'b0;
      if (tx_st == T_IDLE) begin
        if (tx_go) begin
          tx_st <= T_SEND; t_dst <= tx_dst; t_tag <= tx_tag; t_kind <= tx_kind; rcnt <= '0;
        end else if (tx_wr && tx_n < TXC_W'(MAX_WORDS)) begin
          tx_buf[TXI_W'(tx_n)] <= tx_wdata;
          tx_n <= tx_n + 1'b1;
        end
      end
      if (echo_hit) begin
        if (!cur_bsy) begin
          tx_st <= T_IDLE; tx_done <= 1'b1; tx_n <= '0;
        end else if (rcnt == RT_W'(RETRY_LIMIT)) begin
          tx_st <= T_IDLE; tx_fail <= 1'b1; tx_n <= '0;
        end else begin
          tx_st <= T_SEND; rcnt <= rcnt + 1'b1;
        end
      end
      if (ins_on) begin
        ins_idx <= ins_idx + 1'b1;
        if (ins_idx <= ins_len) begin
          out_flag <= 1'b1; out_data <= tx_word; ocrc <= crc_step(ocrc, tx_word);
        end else if (ins_idx == ins_len + 1'b1) begin
          out_flag <= 1'b1; out_data <= ocrc;
        end else begin
          out_flag <= 1'b0; out_data <= '0; ins_on <= 1'b0;
          if (!ins_echo) tx_st <= T_WAIT;
        end
      end else if (byp_pop) begin
        {out_flag, out_data} <= byp_mem[byp_rp];
      end else if (can_ins && eq_any) begin
        out_flag <= 1'b1; out_data <= eq_mem[eq_rp[EQ_AW-1:0]];
        ocrc <= crc_step(16'hFFFF, eq_mem[eq_rp[EQ_AW-1:0]]);
        ins_on <= 1'b1; ins_echo <= 1'b1; ins_idx <= IDX_W'(1); eq_rp <= eq_rp + 1'b1;
      end else if (can_ins && tx_st == T_SEND) begin
        out_flag <= 1'b1; out_data <= tx_hdr; ocrc <= crc_step(16'hFFFF, tx_hdr);
        ins_on <= 1'b1; ins_echo <= 1'b0; ins_idx <= IDX_W'(1);
      end else begin
        out_flag <= 1'b0; out_data <= '0;
      end
    end
  end
endmodule

// File: rtl/ring_node_chk.sv
module ring_node_chk #(
  parameter int BYP_AW   = 6,
  parameter int RX_AW    = 6,
  parameter int RX_DEPTH = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [BYP_AW:0] byp_cnt,
  input logic            ins_on,
  input logic            out_flag,
  input logic            tx_done,
  input logic            tx_ready,
  input logic [RX_AW:0]  cm_ptr,
  input logic [RX_AW:0]  rd_ptr
);
  localparam logic [BYP_AW:0] BYP_CAP = (BYP_AW+1)'(1 << BYP_AW);
  localparam logic [RX_AW:0]  RX_CAP  = (RX_AW+1)'(RX_DEPTH);

  p_byp_bound_r12: assert property (@(posedge clk) disable iff (!rst_n) byp_cnt <= BYP_CAP);
  p_ins_gap_r3:    assert property (@(posedge clk) disable iff (!rst_n) $rose(ins_on) |-> $past(byp_cnt) == '0);
  p_ins_sep_r2:    assert property (@(posedge clk) disable iff (!rst_n) $fell(ins_on) |-> !out_flag);
  p_done_idle_r9:  assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> tx_ready);
  p_rx_bound_r8:   assert property (@(posedge clk) disable iff (!rst_n) (cm_ptr - rd_ptr) <= RX_CAP);
endmodule

bind ring_node ring_node_chk #(.BYP_AW(BYP_AW), .RX_AW(RX_AW), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .byp_cnt(byp_cnt), .ins_on(ins_on), .out_flag(out_flag),
  .tx_done(tx_done), .tx_ready(tx_ready), .cm_ptr(cm_ptr), .rd_ptr(rd_ptr)
);

// File: tb/tb_ring_node.sv
module tb_ring_node;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_flag = 1'b0; logic [15:0] in_data = '0;
  logic out_flag; logic [15:0] out_data;
  logic tx_wr = 1'b0, tx_go = 1'b0, tx_kind = 1'b0;
  logic [15:0] tx_wdata = '0; logic [3:0] tx_dst = '0, tx_tag = '0;
  logic tx_ready, tx_done, tx_fail, rx_valid, rx_first, rx_rd = 1'b0;
  logic [15:0] rx_data;

  ring_node dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] pw [0:63]; int pn;
  logic [15:0] ew [0:63]; int en;
  logic [15:0] mw [$]; int ml [$]; int mcur = 0; logic mprev = 1'b0;
  bit done_seen = 0, fail_seen = 0;

  always @(negedge clk) begin
    if (out_flag) begin mw.push_back(out_data); mcur++; end
    else if (mprev) begin ml.push_back(mcur); mcur = 0; end
    mprev = out_flag;
    if (tx_done) done_seen = 1;
    if (tx_fail) fail_seen = 1;
  end

  function automatic logic [15:0] crc_of(input logic [15:0] a [0:63], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 15; i >= 0; i--)
        c = (c[15] ^ a[k][i]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    return c;
  endfunction

  function automatic logic [15:0] hdr(input int d, s, k, b, t);
    return 16'((d << 12) | (s << 8) | (k << 6) | (b << 5) | t);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    mw.delete(); ml.delete(); done_seen = 0; fail_seen = 0;
  endtask

  task automatic drive_pkt(input bit bad, input int go_at);
    pw[pn] = crc_of(pw, pn) ^ (bad ? 16'h0001 : 16'h0);
    for (int i = 0; i <= pn; i++) begin
      @(negedge clk); in_flag = 1'b1; in_data = pw[i]; tx_go = (i == go_at);
    end
    @(negedge clk); in_flag = 1'b0; in_data = '0; tx_go = 1'b0;
  endtask

  task automatic echo_in(input logic [15:0] h);
    pw[0] = h; pn = 1; drive_pkt(0, -1);
  endtask

  task automatic expect_pkt(input string req);
    int l; bit ok; int act, expv;
    en = en + 1; ew[en-1] = crc_of(ew, en - 1);
    if (ml.size() == 0) begin check(0, req, "packet missing", 0, en); return; end
    l = ml.pop_front(); ok = (l == en); act = l; expv = en;
    for (int i = 0; i < l; i++) begin
      logic [15:0] w = mw.pop_front();
      if (ok && i < en && w != ew[i]) begin ok = 0; act = w; expv = ew[i]; end
    end
    check(ok, req, "packet content/length", act, expv);
  endtask

  task automatic expect_none(input string req);
    check(ml.size() == 0, req, "unexpected output packets", ml.size(), 0);
  endtask

  task automatic load_tx(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_wr = 1'b1; tx_wdata = 16'(base + i);
    end
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic fire_tx(input int d, input int t, input bit k);
    tx_dst = 4'(d); tx_tag = 4'(t); tx_kind = k;
    @(negedge clk); tx_go = 1'b1; @(negedge clk); tx_go = 1'b0;
  endtask

  task automatic read_rx(input logic [15:0] w, input bit first, input string req);
    @(negedge clk);
    check(rx_valid && rx_data == w && rx_first == first, req, "rx word", rx_data, w);
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!out_flag && tx_ready && !rx_valid, "R1", "reset state", {out_flag, tx_ready, rx_valid}, 3'b010);
  endtask

  task automatic t_pass();
    clear_mon();
    pw[0] = hdr(5, 1, 0, 0, 2); pw[1] = 16'h1234; pw[2] = 16'h5678; pw[3] = 16'h9ABC; pn = 4;
    drive_pkt(0, -1);
    pw[0] = hdr(9, 2, 1, 0, 4); pw[1] = 16'hCAFE; pn = 2;
    drive_pkt(0, -1);
    repeat (10) @(negedge clk);
    ew[0] = hdr(5, 1, 0, 0, 2); ew[1] = 16'h1234; ew[2] = 16'h5678; ew[3] = 16'h9ABC; en = 4;
    expect_pkt("R2");
    ew[0] = hdr(9, 2, 1, 0, 4); ew[1] = 16'hCAFE; en = 2;
    expect_pkt("R2");
    check(!rx_valid, "R2", "passing packet stored", rx_valid, 0);
  endtask

  task automatic t_consume();
    clear_mon();
    pw[0] = hdr(3, 6, 0, 0, 9); pw[1] = 16'hA0A0; pw[2] = 16'hB1B1; pn = 3;
    drive_pkt(0, -1);
    repeat (10) @(negedge clk);
    read_rx(hdr(3, 6, 0, 0, 9), 1, "R5");
    read_rx(16'hA0A0, 0, "R5");
    read_rx(16'hB1B1, 0, "R5");
    check(!rx_valid, "R5", "CRC word stored", rx_valid, 0);
    ew[0] = hdr(6, 3, 2, 0, 9); en = 1;
    expect_pkt("R6");
    expect_none("R6");
  endtask

  task automatic t_badcrc();
    clear_mon();
    pw[0] = hdr(3, 6, 0, 0, 1); pw[1] = 16'h7777; pn = 2;
    drive_pkt(1, -1);
    repeat (10) @(negedge clk);
    check(!rx_valid, "R7", "bad packet stored", rx_valid, 0);
    expect_none("R7");
  endtask

  task automatic t_busy();
    int cnt = 0;
    clear_mon();
    for (int p = 1; p <= 2; p++) begin
      pw[0] = hdr(3, 2, 0, 0, p);
      for (int i = 1; i <= 32; i++) pw[i] = 16'(p * 256 + i);
      pn = 33;
      drive_pkt(0, -1);
    end
    repeat (10) @(negedge clk);
    ew[0] = hdr(2, 3, 2, 0, 1); en = 1; expect_pkt("R5");
    ew[0] = hdr(2, 3, 2, 1, 2); en = 1; expect_pkt("R8");
    while (rx_valid && cnt < 100) begin
      rx_rd = 1'b1; @(negedge clk); cnt++;
    end
    rx_rd = 1'b0;
    check(cnt == 33, "R8", "words held after busy", cnt, 33);
  endtask

  task automatic t_tx_ok();
    clear_mon();
    load_tx(3, 16'h1111);
    fire_tx(7, 5, 0);
    check(!tx_ready, "R4", "tx_ready while pending", tx_ready, 0);
    repeat (10) @(negedge clk);
    ew[0] = hdr(7, 3, 0, 0, 5); ew[1] = 16'h1111; ew[2] = 16'h1112; ew[3] = 16'h1113; en = 4;
    expect_pkt("R4");
    echo_in(hdr(3, 7, 2, 0, 5));
    repeat (4) @(negedge clk);
    check(done_seen && tx_ready, "R9", "accept echo completion", {done_seen, tx_ready}, 2'b11);
    expect_none("R11");
  endtask

  task automatic t_retry();
    clear_mon();
    load_tx(2, 16'h4000);
    fire_tx(10, 12, 1);
    repeat (10) @(negedge clk);
    ew[0] = hdr(10, 3, 1, 0, 12); ew[1] = 16'h4000; ew[2] = 16'h4001; en = 3;
    expect_pkt("R4");
    echo_in(hdr(3, 10, 2, 1, 13));
    echo_in(hdr(3, 10, 2, 0, 13));
    repeat (8) @(negedge clk);
    check(!tx_ready && !done_seen, "R11", "mismatched echo acted on", tx_ready, 0);
    expect_none("R11");
    for (int r = 0; r < 3; r++) begin
      echo_in(hdr(3, 10, 2, 1, 12));
      repeat (10) @(negedge clk);
      ew[0] = hdr(10, 3, 1, 0, 12); ew[1] = 16'h4000; ew[2] = 16'h4001; en = 3;
      expect_pkt("R10");
    end
    echo_in(hdr(3, 10, 2, 1, 12));
    repeat (10) @(negedge clk);
    check(fail_seen && tx_ready && !done_seen, "R10", "fail after retry limit", {fail_seen, tx_ready}, 2'b11);
    expect_none("R10");
  endtask

  task automatic t_insert_wait();
    clear_mon();
    load_tx(2, 16'hAA01);
    tx_dst = 4'd1; tx_tag = 4'd2; tx_kind = 1'b0;
    pw[0] = hdr(5, 4, 0, 0, 7);
    for (int i = 1; i <= 10; i++) pw[i] = 16'(16'h5000 + i);
    pn = 11;
    drive_pkt(0, 3);
    repeat (20) @(negedge clk);
    ew[0] = hdr(5, 4, 0, 0, 7);
    for (int i = 1; i <= 10; i++) ew[i] = 16'(16'h5000 + i);
    en = 11;
    expect_pkt("R3");
    ew[0] = hdr(1, 3, 0, 0, 2); ew[1] = 16'hAA01; ew[2] = 16'hAA02; en = 3;
    expect_pkt("R3");
    echo_in(hdr(3, 1, 2, 0, 2));
    repeat (4) @(negedge clk);
    check(tx_ready, "R9", "ack after insertion", tx_ready, 1);
  endtask

  task automatic t_insert_first();
    clear_mon();
    load_tx(4, 16'hBB00);
    tx_dst = 4'd2; tx_tag = 4'd3; tx_kind = 1'b0;
    @(negedge clk); tx_go = 1'b1;
    pw[0] = hdr(6, 4, 0, 0, 8); pw[1] = 16'h6001; pw[2] = 16'h6002; pw[3] = 16'h6003; pn = 4;
    pw[pn] = crc_of(pw, pn);
    for (int i = 0; i <= pn; i++) begin
      @(negedge clk); tx_go = 1'b0; in_flag = 1'b1; in_data = pw[i];
    end
    @(negedge clk); in_flag = 1'b0; in_data = '0;
    repeat (20) @(negedge clk);
    ew[0] = hdr(2, 3, 0, 0, 3);
    for (int i = 0; i < 4; i++) ew[i+1] = 16'(16'hBB00 + i);
    en = 5;
    expect_pkt("R3");
    ew[0] = hdr(6, 4, 0, 0, 8); ew[1] = 16'h6001; ew[2] = 16'h6002; ew[3] = 16'h6003; en = 4;
    expect_pkt("R12");
    echo_in(hdr(3, 2, 2, 0, 3));
    repeat (4) @(negedge clk);
    check(tx_ready && done_seen, "R9", "ack after early insertion", tx_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pass();
    t_consume();
    t_badcrc();
    t_busy();
    t_tx_ok();
    t_retry();
    t_insert_wait();
    t_insert_first();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule